// File: doc/BRIEF.md
# Gate-Drive Protection Supervisor

This block guards a three-phase bridge controller that drives six power switches. It watches an overcurrent comparator output, a logic-supply undervoltage flag and the three active-low low-side command lines. When any of these reports a problem, it raises a single kill signal that turns off every gate output. It also pulls an active-low fault flag, which models an open-drain pin: low means a fault is present and high means the pin is released.

The overcurrent input is asynchronous. It passes through two synchroniser flops and then a blanking filter, so a pulse shorter than the blanking window is ignored. An accepted trip then goes through a fixed propagation delay before the fault latch sets. From that point the trip is committed, even if the comparator has already dropped. The latch holds until three things are true at once: the trip is low, all three low-side commands sit at their inactive high level, and both conditions have lasted for a qualifying time without a break. A select pin chooses between a short and a long qualifying time. An undervoltage is handled separately. It kills the outputs for exactly as long as it lasts and is never latched. The latch comes out of reset set, so nothing switches until a valid clear sequence has run.

Top module: `drv_guard`

## Requirements
- R1: After reset the block is faulted: `kill_all`=1 and `fault_n`=0. It stays faulted while any `lo_cmd_n` bit is 0.
- R2: The synchronised trip must stay high for `BLANK_CYC` consecutive clock cycles to be accepted. A pulse of `BLANK_CYC`-1 cycles causes no fault, while a pulse of `BLANK_CYC` cycles latches one.
- R3: Let edge 1 be the first rising edge that samples `trip_async` high. With the trip held, `kill_all` is still 0 after edge `BLANK_CYC`+`DLY_CYC`+1 and is 1 after edge `BLANK_CYC`+`DLY_CYC`+2.
- R4: Once latched, the fault persists after the trip returns low for as long as any `lo_cmd_n` bit is 0.
- R5: With `fast_clear`=0, suppose `lo_cmd_n`=3'b111 and the synchronised trip is low starting with edge 1. The fault is still present after edge `CLR_LONG`-1 and released after edge `CLR_LONG`.
- R6: With `fast_clear`=1, the same release happens after `CLR_SHORT` qualifying edges instead of `CLR_LONG`.
- R7: The clear timer cannot complete while the trip is high. After the trip falls, a full qualifying time is counted again, starting once the trip has passed through the synchroniser.
- R8: If any `lo_cmd_n` bit goes to 0 during qualification, the timer restarts. The full qualifying time is needed after all bits are high again.
- R9: `supply_low`=1 forces `kill_all`=1 and `fault_n`=0 in the same cycle, without a clock edge. When it returns to 0, the outputs are released unless a trip fault is latched.
- R10: Once a trip has been accepted by the blanking filter, the fault latches after the delay even if the trip input has already returned low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trip_async | input | 1 | Overcurrent comparator output, asynchronous, high = overcurrent |
| supply_low | input | 1 | Logic-supply undervoltage flag, synchronous, high = undervoltage |
| lo_cmd_n | input | 3 | Low-side command per phase, active low, 1 = inactive |
| fast_clear | input | 1 | 1 selects the short clear time, 0 selects the long one |
| kill_all | output | 1 | 1 forces all six gate outputs off |
| fault_n | output | 1 | Fault flag: 0 = pulled low (fault), 1 = released |

## Verification
The bench targets the blanking boundary from both sides, using pulses of exactly `BLANK_CYC`-1 and `BLANK_CYC` cycles. A filter that is off by one would either pass the shorter pulse or reject the longer one. It times both the trip latency and the clear release to the exact edge, for both clear lengths, so a miscounted synchroniser stage or timer would show up one cycle early or late. It holds the trip high during a clear attempt and also interrupts a qualifying window with a one-cycle low-side glitch. A timer that ignored either condition would release the fault early. Undervoltage is checked for an immediate effect with no latching, and randomised trip widths and low-side patterns are compared against a bench model of the acceptance rule.

// File: rtl/drv_guard_pkg.sv
package drv_guard_pkg;

  // Counter width needed to hold values 0..max_val.
  function automatic int unsigned width_for(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

  // Qualifying length of the clear window for the selected variant.
  function automatic int unsigned clear_len(input logic fast,
                                            input int unsigned short_len,
                                            input int unsigned long_len);
    return fast ? short_len : long_len;
  endfunction

endpackage

// File: rtl/drv_guard_sync.sv
module drv_guard_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/drv_guard_qual.sv
module drv_guard_qual
  import drv_guard_pkg::*;
#(
  parameter int unsigned BLANK_CYC = 40,
  parameter int unsigned DLY_CYC   = 26
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  output logic accept_o,
  output logic expire_o,
  output logic busy_o
);
  localparam int unsigned RW = width_for(BLANK_CYC);
  localparam int unsigned DW = width_for(DLY_CYC);

  logic [RW-1:0] run_q;
  logic [DW-1:0] dly_q;
  logic          armed_q;

  // Accept on the BLANK_CYC-th consecutive high cycle; run saturates beyond it.
  assign accept_o = trip_i && (run_q == RW'(BLANK_CYC - 1));
  assign expire_o = armed_q && (dly_q == DW'(DLY_CYC - 1));
  assign busy_o   = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!trip_i) begin
      run_q <= '0;
    end else if (run_q != RW'(BLANK_CYC)) begin
      run_q <= run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      dly_q   <= '0;
    end else if (accept_o) begin
      armed_q <= 1'b1;
      dly_q   <= '0;
    end else if (armed_q) begin
      if (expire_o) armed_q <= 1'b0;
      else          dly_q   <= dly_q + 1'b1;
    end
  end

  // R2: a single run can be accepted only once
  p_accept_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> !accept_o);

  // R10: an accepted trip always starts the delay, regardless of the input afterwards
  p_arm_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> armed_q);
endmodule

// File: rtl/drv_guard_latch.sv
module drv_guard_latch
  import drv_guard_pkg::*;
#(
  parameter int unsigned CLR_SHORT = 200,
  parameter int unsigned CLR_LONG  = 850
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_i,
  input  logic       trip_busy_i,
  input  logic [2:0] lo_cmd_n,
  input  logic       fast_i,
  output logic       latch_o
);
  localparam int unsigned CLR_MAX = (CLR_LONG > CLR_SHORT) ? CLR_LONG : CLR_SHORT;
  localparam int unsigned CW      = width_for(CLR_MAX);

  logic [CW-1:0] cnt_q;
  logic          latch_q;
  logic          idle;
  logic          clr_done;
  logic [CW-1:0] target_m1;

  assign target_m1 = CW'(clear_len(fast_i, CLR_SHORT, CLR_LONG) - 1);
  assign idle      = (&lo_cmd_n) && !trip_busy_i;
  assign clr_done  = latch_q && idle && (cnt_q >= target_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b1;
    end else if (set_i) begin
      latch_q <= 1'b1;
    end else if (clr_done) begin
      latch_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!latch_q || !idle || set_i || clr_done) begin
      cnt_q <= '0;
    end else if (cnt_q != CW'(CLR_MAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign latch_o = latch_q;

  // R4: a latched fault cannot drop while the clear condition is absent
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !idle) |=> latch_q);

  // R5: a release is only ever preceded by an idle cycle
  p_release_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latch_q) |-> $past(idle));

  // R3: a set request always leaves the latch set
  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> latch_q);
endmodule

// File: rtl/drv_guard.sv
module drv_guard #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BLANK_CYC   = 40,
  parameter int unsigned DLY_CYC     = 26,
  parameter int unsigned CLR_SHORT   = 200,
  parameter int unsigned CLR_LONG    = 850
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trip_async,
  input  logic       supply_low,
  input  logic [2:0] lo_cmd_n,
  input  logic       fast_clear,
  output logic       kill_all,
  output logic       fault_n
);
  logic trip_sync;
  logic trip_accept;
  logic trip_expire;
  logic trip_armed;
  logic trip_latched;
  logic fault_any;

  drv_guard_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (trip_async),
    .q_o   (trip_sync)
  );

  drv_guard_qual #(.BLANK_CYC(BLANK_CYC), .DLY_CYC(DLY_CYC)) u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .trip_i   (trip_sync),
    .accept_o (trip_accept),
    .expire_o (trip_expire),
    .busy_o   (trip_armed)
  );

  drv_guard_latch #(.CLR_SHORT(CLR_SHORT), .CLR_LONG(CLR_LONG)) u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_i       (trip_expire),
    .trip_busy_i (trip_sync | trip_armed),
    .lo_cmd_n    (lo_cmd_n),
    .fast_i      (fast_clear),
    .latch_o     (trip_latched)
  );

  assign fault_any = trip_latched | supply_low;
  assign kill_all  = fault_any;
  assign fault_n   = ~fault_any;

  // R9: undervoltage kills the outputs in the same cycle
  p_uv_kill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |-> (kill_all && !fault_n));

  // R7: the fault never releases while the synchronised trip is high
  p_no_clear_in_trip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trip_sync |=> !$fell(trip_latched));

  // R10: an expiring delay always ends with the fault asserted
  p_expire_kills_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trip_expire |=> kill_all);
endmodule

// File: tb/drv_guard_tb_top.sv
module drv_guard_tb_top;
  localparam int B  = 40;
  localparam int D  = 26;
  localparam int LS = 200;
  localparam int LL = 850;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       trip_async;
  logic       supply_low;
  logic [2:0] lo_cmd_n;
  logic       fast_clear;
  logic       kill_all;
  logic       fault_n;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  drv_guard #(.BLANK_CYC(B), .DLY_CYC(D), .CLR_SHORT(LS), .CLR_LONG(LL)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .trip_async (trip_async),
    .supply_low (supply_low),
    .lo_cmd_n   (lo_cmd_n),
    .fast_clear (fast_clear),
    .kill_all   (kill_all),
    .fault_n    (fault_n)
  );

  function automatic int exp_clr(input bit f);
    return f ? LS : LL;
  endfunction

  function automatic bit exp_accept(input int width);
    return width >= B;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_kill(input string req, input bit exp);
    check((kill_all == exp) && (fault_n == !exp), req, int'(kill_all), int'(exp));
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_timed(input bit f, input string req);
    @(negedge clk);
    fast_clear = f;
    lo_cmd_n   = 3'b111;
    edges(exp_clr(f) - 1);
    check_kill({req, " before release"}, 1'b1);
    edges(1);
    check_kill({req, " at release"}, 1'b0);
  endtask

  initial begin
    #3_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int w, lov;
    bit f;
    void'($urandom(32'd2024));
    rst_n = 1'b0; trip_async = 1'b0; supply_low = 1'b0;
    lo_cmd_n = 3'b000; fast_clear = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_kill("R1 reset state", 1'b1);
    edges(LL + 50);
    check_kill("R1 held with low-side active", 1'b1);

    clear_timed(1'b0, "R5 long clear");

    // R3 exact trip latency
    @(negedge clk); lo_cmd_n = 3'b010;
    @(negedge clk); trip_async = 1'b1;
    edges(B + D + 1);
    check_kill("R3 one edge before trip", 1'b0);
    edges(1);
    check_kill("R3 trip latched", 1'b1);
    @(negedge clk); trip_async = 1'b0;
    edges(100);
    check_kill("R4 latch holds after trip low", 1'b1);

    clear_timed(1'b1, "R6 short clear");

    // R2 pulse one cycle too short
    @(negedge clk); lo_cmd_n = 3'b011; trip_async = 1'b1;
    repeat (B - 1) @(negedge clk);
    trip_async = 1'b0;
    edges(B + D + 10);
    check_kill("R2 short pulse ignored", 1'b0);

    // R2/R10 pulse of exact length, dropped before delay ends
    @(negedge clk); trip_async = 1'b1;
    repeat (B) @(negedge clk);
    trip_async = 1'b0;
    edges(B + D + 10);
    check_kill("R2 R10 minimal pulse latches", 1'b1);

    // R7 trip held during clear attempt
    @(negedge clk); trip_async = 1'b1; lo_cmd_n = 3'b111; fast_clear = 1'b1;
    edges(LS + 30);
    check_kill("R7 no clear while trip high", 1'b1);
    @(negedge clk); trip_async = 1'b0;
    edges(LS + 1);
    check_kill("R7 full window after trip fall", 1'b1);
    edges(1);
    check_kill("R7 release after trip fall", 1'b0);

    // R8 glitch on a low-side line restarts the window
    @(negedge clk); lo_cmd_n = 3'b000; trip_async = 1'b1;
    repeat (B + 5) @(negedge clk);
    trip_async = 1'b0;
    edges(B + D + 20);
    check_kill("R8 relatched", 1'b1);
    @(negedge clk); lo_cmd_n = 3'b111;
    edges(LS / 2);
    @(negedge clk); lo_cmd_n = 3'b110;
    @(negedge clk); lo_cmd_n = 3'b111;
    edges(LS - 1);
    check_kill("R8 timer restarted", 1'b1);
    edges(1);
    check_kill("R8 release after restart", 1'b0);

    // R9 undervoltage, immediate and unlatched
    @(negedge clk); supply_low = 1'b1;
    #1;
    check_kill("R9 undervoltage immediate", 1'b1);
    @(negedge clk); supply_low = 1'b0;
    #1;
    check_kill("R9 undervoltage released", 1'b0);
    edges(20);
    check_kill("R9 not latched", 1'b0);

    // Random trip widths and low-side patterns
    for (int i = 0; i < 16; i++) begin
      w   = 1 + int'($urandom_range(2 * B - 1));
      f   = bit'($urandom_range(1));
      lov = int'($urandom_range(6));
      @(negedge clk);
      lo_cmd_n = 3'(lov); fast_clear = f; trip_async = 1'b1;
      repeat (w) @(negedge clk);
      trip_async = 1'b0;
      edges(B + D + 10);
      check_kill("R2 random width", exp_accept(w));
      if (exp_accept(w)) begin
        clear_timed(f, f ? "R6 random clear" : "R5 random clear");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule